// File: doc/BRIEF.md
# Programmable Slot-Table Issue Scheduler

This block picks, once per clock, which hardware thread may issue into a fine-grained multithreaded in-order pipeline. A table of `NUM_SLOTS` entries maps each issue slot to one of `NUM_THREADS` threads, and each entry also carries an enable bit. A slot pointer walks the table in fixed cyclic order, one entry per cycle. The block issues for the thread named in the current entry if that entry is enabled and the thread's ready bit is set. Otherwise the slot becomes a bubble, and no other thread takes it.

Software reprograms the schedule through a single-entry write port. Writes land in a pending copy of the table. The pending copy is moved into the active table when the pointer wraps, so a round of `NUM_SLOTS` cycles always runs from one consistent schedule. At reset the table gives slot i to thread i mod `NUM_THREADS` and enables every slot, which yields plain fixed interleave.

The outputs `issue_valid` and `issue_tid` are registered and updated every cycle. The thread identifier travels down the pipeline with the instruction, so later stages can reach that thread's state. The issue output has no back-pressure: the rotation never waits, because a stalled downstream pipeline would break the fixed timing of the slots. Ready bits, table writes and outputs are all plain level signals.

Top module: `slot_sched_top`

## Requirements
- R1: While `rst_n` is low and until the first clock edge after its release, `issue_valid` is 0 and `issue_tid` is 0. Reset also sets the slot pointer to 0 and makes every entry, both pending and active, read slot i -> thread i mod `NUM_THREADS` with the enable bit at 1.
- R2: With the reset table and all ready bits at 1, the outputs are valid every cycle and `issue_tid` runs 0,1,2,3,0,1,... So each thread issues exactly once in every `NUM_THREADS` cycles.
- R3: At the k-th rising edge after reset release (k counting from 1), the output register loads from slot (k-1) mod `NUM_SLOTS` of the active table. `issue_tid` takes that slot's thread field. `issue_valid` takes that slot's enable bit ANDed with `thr_ready[tid]`, sampled at the same edge.
- R4: If the owner of the current slot is not ready, `issue_valid` is 0 for that slot, whatever the other threads' ready bits are. `issue_tid` still shows the owner.
- R5: A slot whose enable bit is 0 always gives `issue_valid` = 0, even if its owner is ready.
- R6: The slot pointer advances by one per cycle and goes from `NUM_SLOTS`-1 back to 0, with no skipped or repeated slot.
- R7: A write (`tbl_we`=1 at an edge) stores `tbl_tid`/`tbl_enable` into pending entry `tbl_slot`. The active table changes only at the edge where the pointer is at `NUM_SLOTS`-1, and it then takes the whole pending table. A write at that same edge is included. No active entry changes in the middle of a round.
- R8: Several slots may name the same thread, and that thread then issues once for each ready, enabled slot it owns in a round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NUM_THREADS | Per-thread ready bits; bit t is thread t |
| tbl_we | input | 1 | Slot-table write strobe |
| tbl_slot | input | $clog2(NUM_SLOTS) | Entry index to write |
| tbl_tid | input | $clog2(NUM_THREADS) | Thread that will own the entry |
| tbl_enable | input | 1 | Enable bit for the entry (0 = always bubble) |
| issue_valid | output | 1 | 1 = the named thread issues in this slot; 0 = bubble |
| issue_tid | output | $clog2(NUM_THREADS) | Thread of the current slot |

## Verification
Each issue result shows up one edge after the inputs it depends on: the output register loads at edge k from slot (k-1) mod `NUM_SLOTS` and the ready bits sampled at edge k. The bench drives at a falling edge and compares at the next falling edge. Table writes take effect only for the round after the next wrap edge, so the bench model keeps separate pending and active copies and copies one into the other only on the wrap step. A write on the wrap step itself is merged in, and a write earlier in the round is checked to leave the current round unchanged.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  // Owner of a slot after reset: reproduces fixed interleave.
  function automatic int unsigned reset_owner(input int unsigned slot,
                                              input int unsigned nthreads);
    return slot % nthreads;
  endfunction

endpackage

// File: rtl/slot_pointer.sv
module slot_pointer #(
  parameter int NUM_SLOTS = 8,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] ptr,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

  assign wrap = (ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (wrap) ptr <= '0;
    else           ptr <= ptr + SW'(1);
  end

  // R6: one step per cycle, back to zero after the last slot
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != LAST) |=> (ptr == $past(ptr) + SW'(1)));
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == LAST) |=> (ptr == '0));

endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [TW-1:0] wr_tid,
  input  logic          wr_enable,
  input  logic          commit,
  input  logic [SW-1:0] rd_slot,
  output logic [TW-1:0] rd_tid,
  output logic          rd_enable
);
  import slot_sched_pkg::*;

  logic [NUM_SLOTS-1:0][TW-1:0] pend_tid, act_tid;
  logic [NUM_SLOTS-1:0]         pend_en,  act_en;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
    localparam logic [TW-1:0] RST_TID = TW'(reset_owner(g, NUM_THREADS));
    logic hit;
    assign hit = wr_en && (wr_slot == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_tid[g] <= RST_TID;
        pend_en[g]  <= 1'b1;
        act_tid[g]  <= RST_TID;
        act_en[g]   <= 1'b1;
      end else begin
        if (hit) begin
          pend_tid[g] <= wr_tid;
          pend_en[g]  <= wr_enable;
        end
        if (commit) begin
          act_tid[g] <= hit ? wr_tid    : pend_tid[g];
          act_en[g]  <= hit ? wr_enable : pend_en[g];
        end
      end
    end
  end

  assign rd_tid    = act_tid[rd_slot];
  assign rd_enable = act_en[rd_slot];

  // R7: the active schedule never moves inside a round
  p_hold_midround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_tid) && $stable(act_en)));
  // R7: at the wrap without a write, active becomes the pending copy
  p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en) |=> (act_tid == $past(pend_tid) && act_en == $past(pend_en)));

endmodule

// File: rtl/issue_select.sv
module issue_select #(
  parameter int NUM_THREADS = 4,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [TW-1:0]          cur_tid,
  input  logic                   cur_enable,
  output logic                   issue_valid,
  output logic [TW-1:0]          issue_tid
);
  logic owner_ready;
  assign owner_ready = thr_ready[cur_tid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
    end else begin
      issue_valid <= cur_enable && owner_ready;
      issue_tid   <= cur_tid;
    end
  end

  // R4: an issue only ever follows a ready owner
  p_no_steal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(owner_ready));
  // R5: a disabled slot is always a bubble
  p_disabled_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cur_enable) |-> !issue_valid);

endmodule

// File: rtl/slot_sched_top.sv
module slot_sched_top #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic                   tbl_we,
  input  logic [SW-1:0]          tbl_slot,
  input  logic [TW-1:0]          tbl_tid,
  input  logic                   tbl_enable,
  output logic                   issue_valid,
  output logic [TW-1:0]          issue_tid
);
  logic [SW-1:0] ptr;
  logic          wrap;
  logic [TW-1:0] cur_tid;
  logic          cur_enable;

  slot_pointer #(.NUM_SLOTS(NUM_SLOTS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .wrap(wrap)
  );

  slot_table #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_slot(tbl_slot), .wr_tid(tbl_tid), .wr_enable(tbl_enable),
    .commit(wrap), .rd_slot(ptr), .rd_tid(cur_tid), .rd_enable(cur_enable)
  );

  issue_select #(.NUM_THREADS(NUM_THREADS)) u_sel (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
    .cur_tid(cur_tid), .cur_enable(cur_enable),
    .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

endmodule

// File: tb/slot_sched_top_bench.sv
module slot_sched_top_bench;
  localparam int N = 4;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] thr_ready = '0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_slot = '0;
  logic [1:0] tbl_tid = '0;
  logic tbl_enable = 1'b0;
  logic issue_valid;
  logic [1:0] issue_tid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_ptr;
  int m_ptid[S], m_atid[S];
  bit m_pen[S], m_aen[S];

  always #10 clk = ~clk;

  slot_sched_top #(.NUM_THREADS(N), .NUM_SLOTS(S)) u_slot_sched_top (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
    .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_tid(tbl_tid), .tbl_enable(tbl_enable),
    .issue_valid(issue_valid), .issue_tid(issue_tid)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0;
    for (int i = 0; i < S; i++) begin
      m_ptid[i] = i % N; m_atid[i] = i % N;
      m_pen[i] = 1; m_aen[i] = 1;
    end
  endtask

  // Called at a falling edge; compares at the next falling edge.
  task automatic step(input logic [N-1:0] rdy, input bit we, input int ws,
                      input int wt, input bit wen, input string tag);
    int ev, et;
    thr_ready = rdy; tbl_we = we; tbl_slot = 3'(ws); tbl_tid = 2'(wt); tbl_enable = wen;
    @(posedge clk);
    et = m_atid[m_ptr];
    ev = (m_aen[m_ptr] && rdy[et]) ? 1 : 0;
    if (we) begin m_ptid[ws] = wt; m_pen[ws] = wen; end
    if (m_ptr == S - 1) begin
      for (int i = 0; i < S; i++) begin m_atid[i] = m_ptid[i]; m_aen[i] = m_pen[i]; end
      m_ptr = 0;
    end else m_ptr++;
    @(negedge clk);
    chk(tag, "issue_valid", int'(issue_valid), ev);
    chk(tag, "issue_tid", int'(issue_tid), et);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1", "issue_valid in reset", int'(issue_valid), 0);
    chk("R1", "issue_tid in reset", int'(issue_tid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "issue_valid after release", int'(issue_valid), 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 R6: default fixed interleave, all threads ready
    for (int k = 0; k < 2 * S; k++) step(4'hF, 0, 0, 0, 0, "R2 R6 R3");
    // R4: every ready pattern for one full round each
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < S; k++) step(4'(p), 0, 0, 0, 0, "R4");
    // R7: reprogram during a round; that round keeps the old schedule.
    // Thread 0 owns slots 0..3 (R8), slot 6 disabled (R5).
    for (int k = 0; k < S; k++) begin
      int wt, we_n;
      wt = (k < 4) ? 0 : (k == 4) ? 1 : (k == 5) ? 2 : 3;
      we_n = (k == 6) ? 0 : 1;
      step(4'hF, 1, k, wt, we_n[0], "R7");
    end
    // R5 R8: new schedule under varying readiness
    for (int k = 0; k < 4 * S; k++) step(4'((k * 5 + 3) & 15), 0, 0, 0, 0, "R5 R8");
    for (int k = 0; k < S; k++) step(4'hF, 0, 0, 0, 0, "R8");
    // R7: write slot 7 early in a round; current round must ignore it
    step(4'hF, 0, 0, 0, 0, "R7");
    step(4'hF, 1, 7, 1, 1, "R7");
    for (int k = 2; k < S; k++) step(4'hF, 0, 0, 0, 0, "R7");
    // R7: write slot 0 on the wrap step; next round uses it
    for (int k = 0; k < S - 1; k++) step(4'hF, 0, 0, 0, 0, "R7");
    step(4'hF, 1, 0, 2, 1, "R7");
    for (int k = 0; k < S; k++) step(4'hF, 0, 0, 0, 0, "R7");
    // R5: disabled slot with ready owner
    for (int k = 0; k < S; k++) step(4'h8, 0, 0, 0, 0, "R5");
    // R1: reset restores the fixed interleave
    do_reset();
    for (int k = 0; k < S; k++) step(4'hF, 0, 0, 0, 0, "R1 R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule